// File: doc/BRIEF.md
# Protection Region Register File

This block holds the software-visible programming state for a bank of memory protection regions. A single 32-bit register port with a 12-bit offset reaches a type word, a control word, a region-number register, a base word and an attribute word for each region, and two attribute-indirection words. Base and attribute words are reached through four aliased offset pairs. Which region an access reaches depends on the region-number register, the alias used and the layout mode.

A static `new_mode` input picks one of two layouts. In the legacy layout, every alias reaches the region named by the region-number register. A base write may carry its own region number, guarded by a valid bit. Stored fields are masked. In the newer layout, the alias index replaces the two low bits of the region number. Full 32-bit words are stored, and the indirection words become available. The current region number is driven out so that a separate access checker can use it. This block does no address matching or permission checking.

Each access is sorted into one of eight target kinds: `K_NONE`, `K_TYPE`, `K_CTRL`, `K_RNR`, `K_BASE`, `K_ATTR`, `K_MAIR0` and `K_MAIR1`. The target kind then selects the write action and the read source. There is no multi-cycle sequencing: every access completes in the cycle in which it is presented.

Top module: `mpr_regfile`

## Requirements
- R1: After reset, every register reads zero and `cur_region` is 0.
- R2: A write to the region-number register (offset 0xD98) stores the value only if it is below `NUM_REGIONS`. Any larger value, judged on all 32 bits, is ignored.
- R3: The base words sit at 0xD9C, 0xDA4, 0xDAC and 0xDB4, and the attribute words sit at 0xDA0, 0xDA8, 0xDB0 and 0xDB8. Alias index = (offset − first offset of its kind) / 8, which gives 0 to 3. In the legacy layout, every alias reaches the region held in the region-number register.
- R4: In the legacy layout, a base write with bit 4 set targets the region given by bits [3:0] and also loads that number into the region-number register. If that field is not below `NUM_REGIONS`, the whole write is dropped.
- R5: In the legacy layout, a base write stores the value with bits [4:0] cleared. A base read returns the stored base ORed with the region number in bits [3:0].
- R6: In the legacy layout, an attribute write keeps bits [15:0] masked by 0xFF3F as the size field and bits [31:16] masked by 0x173F as the access field. A read returns the access field in [31:16] and the size field in [15:0].
- R7: In the newer layout, the target region is the region number with bits [1:0] replaced by the alias index. Base and attribute words are stored and returned in full 32 bits. Bit 4 of a base write has no special meaning.
- R8: The control word at 0xD94 keeps only bits [2:0]: bit 0 enable, bit 1 fault-handler enable, bit 2 privileged default map. All other bits read zero.
- R9: The type word at 0xD90 reads `NUM_REGIONS << 8` and ignores writes.
- R10: The indirection words at 0xDC0 and 0xDC4 are stored and read back in full in the newer layout. In the legacy layout they read zero and ignore writes.
- R11: Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read. Unmapped offsets read zero.
- R12: `cur_region` always equals the region-number register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_mode | input | 1 | 1 selects the newer layout, 0 the legacy layout |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| offset | input | 12 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cur_region | output | 4 | Current region number |

## Verification
Base words are written through different aliases and then read back through other aliases. In the legacy layout this shows that the alias is ignored. In the newer layout it shows that the alias replaces the low region bits. Base writes are tried with the valid bit clear, with the valid bit set and an in-range region, and with the valid bit set and an out-of-range region. Comparing the region number and the base read-back after each of these separates redirection, dropping and plain storage. All-ones and mixed patterns are written to attribute, control and indirection words in both layouts. This shows which bits each mask keeps and whether the layout mode gates the indirection words.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int unsigned OFF_W  = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned RID_W  = 4;

    localparam logic [OFF_W-1:0] OFF_TYPE   = 12'hD90;
    localparam logic [OFF_W-1:0] OFF_CTRL   = 12'hD94;
    localparam logic [OFF_W-1:0] OFF_RNR    = 12'hD98;
    localparam logic [OFF_W-1:0] OFF_BASE0  = 12'hD9C;
    localparam logic [OFF_W-1:0] OFF_ATTR0  = 12'hDA0;
    localparam logic [OFF_W-1:0] OFF_MAIR0  = 12'hDC0;
    localparam logic [OFF_W-1:0] OFF_MAIR1  = 12'hDC4;

    localparam logic [DATA_W-1:0] BASE_KEEP   = 32'hFFFF_FFE0;
    localparam logic [15:0]       SIZE_KEEP   = 16'hFF3F;
    localparam logic [15:0]       ACCESS_KEEP = 16'h173F;
    localparam int unsigned       CTRL_W      = 3;

    typedef enum logic [2:0] {
        K_NONE,
        K_TYPE,
        K_CTRL,
        K_RNR,
        K_BASE,
        K_ATTR,
        K_MAIR0,
        K_MAIR1
    } target_e;

endpackage

// File: rtl/mpr_decode.sv
module mpr_decode
    import mpr_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    input  logic             new_mode,
    input  logic [RID_W-1:0] rnr,
    output target_e          kind,
    output logic [1:0]       alias_idx,
    output logic [RID_W-1:0] eff_region
);

    always_comb begin
        kind      = K_NONE;
        alias_idx = 2'd0;
        unique case (offset)
            OFF_TYPE:  kind = K_TYPE;
            OFF_CTRL:  kind = K_CTRL;
            OFF_RNR:   kind = K_RNR;
            12'hD9C:   begin kind = K_BASE; alias_idx = 2'd0; end
            12'hDA4:   begin kind = K_BASE; alias_idx = 2'd1; end
            12'hDAC:   begin kind = K_BASE; alias_idx = 2'd2; end
            12'hDB4:   begin kind = K_BASE; alias_idx = 2'd3; end
            12'hDA0:   begin kind = K_ATTR; alias_idx = 2'd0; end
            12'hDA8:   begin kind = K_ATTR; alias_idx = 2'd1; end
            12'hDB0:   begin kind = K_ATTR; alias_idx = 2'd2; end
            12'hDB8:   begin kind = K_ATTR; alias_idx = 2'd3; end
            OFF_MAIR0: kind = new_mode ? K_MAIR0 : K_NONE;
            OFF_MAIR1: kind = new_mode ? K_MAIR1 : K_NONE;
            default:   kind = K_NONE;
        endcase
    end

    // Newer layout: the alias replaces the two low bits of the region number.
    assign eff_region = new_mode ? {rnr[RID_W-1:2], alias_idx} : rnr;

endmodule

// File: rtl/mpr_region_bank.sv
module mpr_region_bank
    import mpr_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic              wr_attr,
    input  logic [RID_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] base_in,
    input  logic [DATA_W-1:0] attr_in,
    input  logic [RID_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] base_out,
    output logic [DATA_W-1:0] attr_out
);

    logic [DATA_W-1:0] base_q [NUM_REGIONS];
    logic [DATA_W-1:0] attr_q [NUM_REGIONS];

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        localparam logic [RID_W-1:0] MY_IDX = RID_W'(g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                attr_q[g] <= '0;
            end else begin
                if (wr_base && wr_idx == MY_IDX) base_q[g] <= base_in;
                if (wr_attr && wr_idx == MY_IDX) attr_q[g] <= attr_in;
            end
        end
    end

    // An index with no implemented region reads zero.
    always_comb begin
        base_out = '0;
        attr_out = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (rd_idx == RID_W'(i)) begin
                base_out = base_q[i];
                attr_out = attr_q[i];
            end
        end
    end

endmodule

// File: rtl/mpr_regfile.sv
module mpr_regfile
    import mpr_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_mode,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [11:0]       offset,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [3:0]        cur_region
);

    localparam logic [DATA_W-1:0] REGION_LIMIT = DATA_W'(NUM_REGIONS);
    localparam logic [DATA_W-1:0] TYPE_WORD    = DATA_W'(NUM_REGIONS) << 8;
    localparam bit                MAIR_WRITABLE = (NUM_REGIONS > 0);

    logic [RID_W-1:0]  rnr_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] mair0_q, mair1_q;
    logic [DATA_W-1:0] rdata_q;

    target_e           kind;
    logic [1:0]        alias_idx;
    logic [RID_W-1:0]  eff_region;

    mpr_decode u_decode (
        .offset     (offset),
        .new_mode   (new_mode),
        .rnr        (rnr_q),
        .kind       (kind),
        .alias_idx  (alias_idx),
        .eff_region (eff_region)
    );

    // Write target selection
    logic              legacy_redirect;
    logic [RID_W-1:0]  wr_idx;
    logic              wr_idx_ok;
    logic              wr_base, wr_attr, wr_rnr;
    logic [RID_W-1:0]  rnr_next;
    logic [DATA_W-1:0] base_in, attr_in;

    always_comb begin
        legacy_redirect = !new_mode && kind == K_BASE && wdata[4];
        wr_idx    = legacy_redirect ? wdata[RID_W-1:0] : eff_region;
        wr_idx_ok = {28'd0, wr_idx} < REGION_LIMIT;
        wr_base   = wr_en && kind == K_BASE && wr_idx_ok;
        wr_attr   = wr_en && kind == K_ATTR && wr_idx_ok;
        wr_rnr    = 1'b0;
        rnr_next  = rnr_q;
        if (wr_en && kind == K_RNR && wdata < REGION_LIMIT) begin
            wr_rnr   = 1'b1;
            rnr_next = wdata[RID_W-1:0];
        end else if (wr_en && legacy_redirect && wr_idx_ok) begin
            wr_rnr   = 1'b1;
            rnr_next = wdata[RID_W-1:0];
        end
        base_in = new_mode ? wdata : (wdata & BASE_KEEP);
        attr_in = new_mode ? wdata
                           : {wdata[31:16] & ACCESS_KEEP, wdata[15:0] & SIZE_KEEP};
    end

    logic [DATA_W-1:0] bank_base, bank_attr;

    mpr_region_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_base  (wr_base),
        .wr_attr  (wr_attr),
        .wr_idx   (wr_idx),
        .base_in  (base_in),
        .attr_in  (attr_in),
        .rd_idx   (eff_region),
        .base_out (bank_base),
        .attr_out (bank_attr)
    );

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnr_q   <= '0;
            ctrl_q  <= '0;
            mair0_q <= '0;
            mair1_q <= '0;
        end else begin
            if (wr_rnr) rnr_q <= rnr_next;
            if (wr_en && kind == K_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
            if (wr_en && kind == K_MAIR0 && MAIR_WRITABLE) mair0_q <= wdata;
            if (wr_en && kind == K_MAIR1 && MAIR_WRITABLE) mair1_q <= wdata;
        end
    end

    // Read source selection
    logic              rd_idx_ok;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_idx_ok = {28'd0, eff_region} < REGION_LIMIT;
        rd_next   = '0;
        unique case (kind)
            K_TYPE:  rd_next = TYPE_WORD;
            K_CTRL:  rd_next = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            K_RNR:   rd_next = {28'd0, rnr_q};
            K_BASE:  if (rd_idx_ok)
                         rd_next = new_mode ? bank_base : (bank_base | {28'd0, eff_region});
            K_ATTR:  if (rd_idx_ok) rd_next = bank_attr;
            K_MAIR0: rd_next = mair0_q;
            K_MAIR1: rd_next = mair1_q;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_next;
    end

    assign rdata      = rdata_q;
    assign cur_region = rnr_q;

    // Checks
    a_r2_rnr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        {28'd0, cur_region} < REGION_LIMIT);

    a_r2_big_rnr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == OFF_RNR && wdata >= REGION_LIMIT) |=> $stable(cur_region));

    a_r9_type_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && offset == OFF_TYPE) |=> rdata == TYPE_WORD);

    a_r6_attr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !new_mode && kind == K_ATTR) |=> (rdata & ~32'h173F_FF3F) == 32'd0);

    a_r5_base_region_or: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !new_mode && kind == K_BASE) |=>
            (rdata[3:0] & $past(cur_region)) == $past(cur_region));

    a_r10_mair_legacy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !new_mode && (offset == OFF_MAIR0 || offset == OFF_MAIR1)) |=> rdata == 32'd0);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !$past(rd_en)) |=> $stable(rdata));

    a_r8_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && offset == OFF_CTRL) |=> rdata[31:3] == 29'd0);

endmodule

// File: tb/mpr_regfile_test.sv
module mpr_regfile_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        new_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] offset = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  cur_region;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mpr_regfile uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .new_mode   (new_mode),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .offset     (offset),
        .wdata      (wdata),
        .rdata      (rdata),
        .cur_region (cur_region)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] off, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; offset = off; wdata = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: push expected item, then issue the read
    task automatic rd(input logic [11:0] off, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1; offset = off;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: compare one cycle after each accepted read, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en && rst_n) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk("R11 unexpected read", rdata, 32'hx);
                end else begin
                    automatic logic [31:0] e = exp_q.pop_front();
                    automatic string       t = tag_q.pop_front();
                    chk(t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cur_region / R12", {28'd0, cur_region}, 32'd0);
        chk("R1 reset rdata", rdata, 32'd0);
        rd(12'hD94, 32'd0, "R1 ctrl after reset");
        rd(12'hD98, 32'd0, "R1 rnr after reset");
        rd(12'hDA0, 32'd0, "R1 attr after reset");

        // Legacy layout
        rd(12'hD90, 32'h0000_0800, "R9 type word");
        wr(12'hD90, 32'h0000_FFFF);
        rd(12'hD90, 32'h0000_0800, "R9 type ignores write");
        wr(12'hD94, 32'hFFFF_FFFF);
        rd(12'hD94, 32'h0000_0007, "R8 ctrl keeps three bits");

        wr(12'hD98, 32'd3);
        rd(12'hD98, 32'd3, "R2 rnr stores in-range");
        chk("R12 cur_region follows", {28'd0, cur_region}, 32'd3);
        wr(12'hD98, 32'd8);
        rd(12'hD98, 32'd3, "R2 rnr ignores count");
        wr(12'hD98, 32'hFFFF_FFF1);
        rd(12'hD98, 32'd3, "R2 rnr ignores high bits");

        wr(12'hD9C, 32'h1234_5677);
        rd(12'hD98, 32'd7, "R4 valid bit loads rnr");
        rd(12'hD9C, 32'h1234_5667, "R5 base masked or region");

        wr(12'hD98, 32'd2);
        wr(12'hDAC, 32'hABCD_EF05);
        rd(12'hDA4, 32'hABCD_EF02, "R3 legacy aliases share region");
        wr(12'hD9C, 32'h5555_551A);
        rd(12'hD98, 32'd2, "R4 out-of-range valid drops rnr");
        rd(12'hDB4, 32'hABCD_EF02, "R4 out-of-range valid drops base");

        wr(12'hDB8, 32'hFFFF_FFFF);
        rd(12'hDA0, 32'h173F_FF3F, "R6 attr masks all ones");
        wr(12'hDA8, 32'h1234_5678);
        rd(12'hDB0, 32'h1234_5638, "R6 attr masks pattern");

        wr(12'hDC0, 32'hDEAD_BEEF);
        rd(12'hDC0, 32'd0, "R10 mair legacy reads zero");
        rd(12'hD8C, 32'd0, "R11 unmapped reads zero");

        // Newer layout
        new_mode = 1'b1;
        wr(12'hDA4, 32'hCAFE_F01F);
        rd(12'hDA4, 32'hCAFE_F01F, "R7 full base alias1");
        chk("R7 valid bit inert", {28'd0, cur_region}, 32'd2);
        wr(12'hD98, 32'd5);
        wr(12'hDB4, 32'h0000_00FF);
        rd(12'hDB4, 32'h0000_00FF, "R7 alias3 region7");
        rd(12'hD9C, 32'd0, "R7 alias0 region4 untouched");
        wr(12'hDB0, 32'hFFFF_FFFF);
        rd(12'hDB0, 32'hFFFF_FFFF, "R7 full attr alias2");
        rd(12'hDC0, 32'd0, "R10 legacy write was ignored");
        wr(12'hDC0, 32'hDEAD_BEEF);
        wr(12'hDC4, 32'h0102_0304);
        rd(12'hDC0, 32'hDEAD_BEEF, "R10 mair0 newer");
        rd(12'hDC4, 32'h0102_0304, "R10 mair1 newer");
        repeat (3) @(negedge clk);
        chk("R11 rdata holds", rdata, 32'h0102_0304);

        new_mode = 1'b0;
        rd(12'hDA4, 32'h0000_0005, "R3 legacy back to rnr region");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("R11 pending reads", 32'(exp_q.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule